// File: doc/BRIEF.md
# Four-Way Branch Microcode Sequencer

This block is a table-driven controller. Its state register holds a small state number. Every cycle, the controller picks two condition bits out of a wider condition vector. The state decides which two bits it picks. Those two bits and the state form the address of a constant control store of 64 words. Each word carries the next state and a control field, and both are registered on the same clock edge. Every state therefore branches four ways, and the condition inputs it does not select cannot steer it.

The control store and the per-state select table are constants that are computed when the design elaborates, so no contents are loaded from outside. The microprogram is fixed by formula, and the requirements below spell it out. The control signals and the state are plain registered outputs. There is no data stream and so no handshake: the condition inputs are sampled on every rising edge.

Top module: `seq4_branch`

## Requirements
- R1: A synchronous active-high `rst` sets `state_q` to 0 and `ctrl_q` to 8'hF3, which is the control word at store address 0.
- R2: The store address is 6 bits, {state_q[3:0], c1, c0}, with the state in the high bits. This gives 64 words, each holding a 4-bit next state and an 8-bit control field.
- R3: Condition select 0 is state_q[2:0]. Bit c0 is cond[state_q[2:0]].
- R4: Condition select 1 is the bitwise inverse of state_q[2:0]. Bit c1 is cond[~state_q[2:0]], so the two picked inputs always differ.
- R5: On each clock edge without reset, state_q becomes (3*s + 1 + 5*b) mod 16. Here s is the old state and b = 2*c1 + c0.
- R6: On the same edge, ctrl_q becomes {~s[3:0], b[1:0], ~b[1:0]}.
- R7: The four values of b yield four distinct successors for every state: offsets 0, 5, 10 and 15 from (3*s+1) mod 16.
- R8: The six condition inputs that the current state does not select have no effect on the next state_q or ctrl_q.
- R9: Reset takes priority over the conditions: while `rst` is high, the condition values do not matter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cond | input | 8 | Condition inputs; two of them are picked each cycle |
| state_q | output | 4 | Registered current state |
| ctrl_q | output | 8 | Registered control field from the store word |

## Verification
Two functions meet in one cycle. The first is the two-bit branch pick: the per-state muxes choose the bits and those bits index the store. The second is the synchronous reset, which must override whatever branch the picked bits would take. The bench raises `rst` at random points while the picked conditions would steer to a non-zero successor. It judges that edge by requiring state 0 and the control word 8'hF3. The bench also flips only the unpicked inputs from the same state and requires an identical successor.

// File: rtl/seq4_pkg.sv
package seq4_pkg;
  // Default geometry of the sequencer
  localparam int STATE_W_DEF = 4;
  localparam int COND_N_DEF  = 8;
  // Number of branch bits fed into the store address
  localparam int BR_W        = 2;
  // Width of the per-state fields that go beside the state in a control word
  localparam int CTRL_TAG_W  = 2 * BR_W;
endpackage

// File: rtl/seq4_cond_mux.sv
module seq4_cond_mux #(
  parameter int COND_N = 8,
  parameter int SEL_W  = $clog2(COND_N)
) (
  input  logic [COND_N-1:0] cond,
  input  logic [SEL_W-1:0]  sel,
  output logic              bit_o
);
  always_comb begin
    bit_o = 1'b0;
    for (int i = 0; i < COND_N; i++) begin
      if (sel == SEL_W'(i)) bit_o = cond[i];
    end
  end
endmodule

// File: rtl/seq4_sel_table.sv
module seq4_sel_table #(
  parameter int STATE_W = 4,
  parameter int SEL_W   = 3
) (
  input  logic [STATE_W-1:0] state,
  output logic [SEL_W-1:0]   sel0,
  output logic [SEL_W-1:0]   sel1
);
  localparam int N_ST = 1 << STATE_W;

  logic [SEL_W-1:0] tab0 [N_ST];
  logic [SEL_W-1:0] tab1 [N_ST];

  // Per-state select fields, computed when the design elaborates
  for (genvar s = 0; s < N_ST; s++) begin : g_tab
    assign tab0[s] = SEL_W'(s);
    assign tab1[s] = ~SEL_W'(s);
  end

  assign sel0 = tab0[state];
  assign sel1 = tab1[state];
endmodule

// File: rtl/seq4_rom.sv
module seq4_rom #(
  parameter int STATE_W = 4,
  parameter int CTRL_W  = STATE_W + seq4_pkg::CTRL_TAG_W
) (
  input  logic [STATE_W+seq4_pkg::BR_W-1:0] addr,
  output logic [STATE_W-1:0]                nxt,
  output logic [CTRL_W-1:0]                 ctrl
);
  import seq4_pkg::*;

  localparam int ADDR_W = STATE_W + BR_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = STATE_W + CTRL_W;

  function automatic logic [WORD_W-1:0] word_at(int a);
    logic [STATE_W-1:0] s;
    logic [BR_W-1:0]    b;
    logic [STATE_W-1:0] n;
    s = STATE_W'(a >> BR_W);
    b = BR_W'(a);
    n = STATE_W'(3 * int'(s) + 1 + 5 * int'(b));
    return {n, ~s, b, ~b};
  endfunction

  logic [WORD_W-1:0] mem [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_word
    assign mem[a] = word_at(a);
  end

  logic [WORD_W-1:0] word;
  assign word = mem[addr];
  assign nxt  = word[WORD_W-1 -: STATE_W];
  assign ctrl = word[CTRL_W-1:0];
endmodule

// File: rtl/seq4_branch.sv
module seq4_branch #(
  parameter int STATE_W = seq4_pkg::STATE_W_DEF,
  parameter int COND_N  = seq4_pkg::COND_N_DEF
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic [COND_N-1:0]                        cond,
  output logic [STATE_W-1:0]                       state_q,
  output logic [STATE_W+seq4_pkg::CTRL_TAG_W-1:0]  ctrl_q
);
  import seq4_pkg::*;

  localparam int SEL_W  = $clog2(COND_N);
  localparam int CTRL_W = STATE_W + CTRL_TAG_W;
  localparam int ADDR_W = STATE_W + BR_W;
  localparam logic [CTRL_W-1:0] RST_CTRL = {{STATE_W{1'b1}}, {BR_W{1'b0}}, {BR_W{1'b1}}};

  logic [SEL_W-1:0]   sel [BR_W];
  logic [BR_W-1:0]    br;
  logic [ADDR_W-1:0]  addr;
  logic [STATE_W-1:0] nxt;
  logic [CTRL_W-1:0]  ctrl_d;

  seq4_sel_table #(.STATE_W(STATE_W), .SEL_W(SEL_W)) i_sel (
    .state (state_q),
    .sel0  (sel[0]),
    .sel1  (sel[1])
  );

  for (genvar k = 0; k < BR_W; k++) begin : g_mux
    seq4_cond_mux #(.COND_N(COND_N), .SEL_W(SEL_W)) i_mux (
      .cond  (cond),
      .sel   (sel[k]),
      .bit_o (br[k])
    );
  end

  assign addr = {state_q, br};

  seq4_rom #(.STATE_W(STATE_W), .CTRL_W(CTRL_W)) i_rom (
    .addr (addr),
    .nxt  (nxt),
    .ctrl (ctrl_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      ctrl_q  <= RST_CTRL;
    end else begin
      state_q <= nxt;
      ctrl_q  <= ctrl_d;
    end
  end
endmodule

// File: rtl/seq4_branch_chk.sv
module seq4_branch_chk #(
  parameter int STATE_W = 4,
  parameter int COND_N  = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic [COND_N-1:0]          cond,
  input logic [STATE_W-1:0]         state_q,
  input logic [STATE_W+4-1:0]       ctrl_q
);
  localparam int SEL_W = $clog2(COND_N);

  logic               seen = 1'b0;
  logic               rst_d = 1'b0;
  logic [STATE_W-1:0] p_state = '0;
  logic [COND_N-1:0]  p_cond = '0;

  always_ff @(posedge clk) begin
    seen    <= !rst;
    rst_d   <= rst;
    p_state <= state_q;
    p_cond  <= cond;
  end

  logic [SEL_W-1:0] ps0, ps1;
  logic [1:0]       pb;
  logic [STATE_W-1:0] base, off;
  assign ps0  = p_state[SEL_W-1:0];
  assign ps1  = ~p_state[SEL_W-1:0];
  assign pb   = {p_cond[ps1], p_cond[ps0]};
  assign base = STATE_W'(3 * int'(p_state) + 1);
  assign off  = state_q - base;

  always @(posedge clk) begin
    if (rst_d) begin
      AST_RESET_WORD: assert (state_q == '0 && ctrl_q == {{STATE_W{1'b1}}, 4'b0011}); // R1
    end
  end

  AST_NEXT_STATE: assert property (@(posedge clk) disable iff (rst)
    seen |-> state_q == STATE_W'(3 * int'(p_state) + 1 + 5 * int'(pb))); // R5

  AST_CTRL_FIELD: assert property (@(posedge clk) disable iff (rst)
    seen |-> ctrl_q == {~p_state, pb, ~pb}); // R6

  AST_FOUR_WAY: assert property (@(posedge clk) disable iff (rst)
    seen |-> (off == STATE_W'(0) || off == STATE_W'(5) ||
              off == STATE_W'(10) || off == STATE_W'(15))); // R7
endmodule

bind seq4_branch seq4_branch_chk #(.STATE_W(STATE_W), .COND_N(COND_N)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .cond    (cond),
  .state_q (state_q),
  .ctrl_q  (ctrl_q)
);

// File: tb/test_seq4_branch.sv
`timescale 1ns/1ps
module test_seq4_branch;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cond = 8'h00;
  logic [3:0] state_q;
  logic [7:0] ctrl_q;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  bit cov [64];

  always #2.5 clk = ~clk;

  seq4_branch i_seq4_branch (
    .clk(clk), .rst(rst), .cond(cond), .state_q(state_q), .ctrl_q(ctrl_q)
  );

  // Model from the requirements
  function automatic logic [1:0] pick(logic [3:0] s, logic [7:0] c);
    logic [2:0] s0, s1;
    s0 = s[2:0];      // R3
    s1 = ~s[2:0];     // R4
    return {c[s1], c[s0]};
  endfunction
  function automatic logic [3:0] m_next(logic [3:0] s, logic [7:0] c);
    return 4'(3 * int'(s) + 1 + 5 * int'(pick(s, c)));   // R5
  endfunction
  function automatic logic [7:0] m_ctrl(logic [3:0] s, logic [7:0] c);
    logic [1:0] b;
    b = pick(s, c);
    return {~s, b, ~b};                                   // R6
  endfunction

  task automatic check(string req, logic [3:0] es, logic [7:0] ec);
    vectors++;
    if (state_q !== es || ctrl_q !== ec) begin
      miscompares++;
      $display("FAIL %s: state=%h ctrl=%h expected state=%h ctrl=%h", req, state_q, ctrl_q, es, ec);
    end
  endtask

  // one edge with given inputs; returns after the next falling edge
  task automatic step(logic r, logic [7:0] c);
    rst = r; cond = c;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [3:0] s;
    logic [7:0] c, es_a, ec_a;
    logic [3:0] es;
    void'($urandom(32'd1234));
    @(negedge clk);
    step(1'b1, 8'hFF);
    check("R1", 4'h0, 8'hF3);

    // R7 / R2: directed, all four branches of state 0 and of its successors
    for (int b = 0; b < 4; b++) begin
      step(1'b1, 8'h00);
      c = {b[1], 6'b0, b[0]};          // state 0 picks bits 0 and 7
      es = m_next(4'h0, c);
      step(1'b0, c);
      check("R7", es, m_ctrl(4'h0, c));
      if (es !== 4'(1 + 5 * b)) begin
        vectors++; miscompares++;
        $display("FAIL R7: model successor %h expected %h", es, 4'(1 + 5 * b));
      end
    end

    // R8: only unselected inputs changed from state 0
    for (int k = 0; k < 8; k++) begin
      c = 8'($urandom);
      step(1'b1, 8'h00);
      step(1'b0, c);
      es_a = {4'h0, state_q}; ec_a = ctrl_q;
      step(1'b1, 8'h00);
      step(1'b0, c ^ 8'h7E);
      check("R8", es_a[3:0], ec_a);
    end

    // Random walk with occasional reset (R5, R6, R9)
    step(1'b1, 8'h00);
    s = 4'h0;
    for (int n = 0; n < 3000; n++) begin
      c = 8'($urandom);
      if ($urandom_range(0, 19) == 0) begin
        step(1'b1, c);
        check("R9", 4'h0, 8'hF3);
        s = 4'h0;
      end else begin
        cov[{s, pick(s, c)}] = 1'b1;
        es = m_next(s, c);
        step(1'b0, c);
        check("R5", es, m_ctrl(s, c));
        s = es;
      end
    end

    // R7 coverage: every state took all four branches
    for (int a = 0; a < 64; a++) begin
      vectors++;
      if (!cov[a]) begin
        miscompares++;
        $display("FAIL R7: address %0d covered=0 expected=1", a);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule